// File: doc/BRIEF.md
# Halt and Watchdog Power Controller

This block governs the power-down state of a small microcontroller core and the watchdog timer that watches over it. The instruction decoder sends a single-cycle halt strobe. The controller then drops the core's clock enable, zeroes the watchdog count, raises the power-down flag and lowers the time-out flag. Registers and I/O are left untouched. No reset or clear goes toward them. The core stays halted until one of two events occurs: an external wake request, or a watchdog overflow. Either event restores the clock enable on the next cycle. A watchdog overflow during normal running does not wake anything. It sets the time-out flag and issues a one-cycle reset request.

The watchdog can count one of two tick sources. The first is a free-running low-rate oscillator tick, which keeps counting during halt; a configuration bit can switch that oscillator off. The second is a tick taken from the core clock divided by four, which is gated along with the core clock and therefore freezes during halt. The same divide-by-four chain drives a synchronization output that other devices can use. The control is a two-state machine: `PM_RUN` and `PM_HALT`. It has three named transitions: *enter* (`PM_RUN` to `PM_HALT` on the halt strobe), *wake* (`PM_HALT` to `PM_RUN` on the wake request) and *expire* (`PM_HALT` to `PM_RUN` on a watchdog overflow).

Top module: `halt_wdt_ctrl`

## Requirements
- R1: After reset `sys_clk_en` is 1, and `pd_flag`, `to_flag`, `rst_req` and `sync_out` are 0.
- R2: A `halt_req` pulse while running drives `sys_clk_en` to 0 from the next cycle, and it stays 0 until a wake or an overflow.
- R3: On halt entry the watchdog count restarts from zero, `pd_flag` becomes 1 and `to_flag` becomes 0.
- R4: With `cfg_wdt_src`=0 and `cfg_osc_en`=1, each `osc_tick` pulse advances the watchdog, in run and in halt alike. An overflow occurs on the 2^WDT_W-th tick after a clear.
- R5: With `cfg_wdt_src`=0 and `cfg_osc_en`=0, the watchdog never advances, so `to_flag` stays 0.
- R6: With `cfg_wdt_src`=1, the watchdog advances once per four clock-enabled cycles (on the enabled cycle where the divider wraps). It is frozen while halted.
- R7: An overflow while halted sets `to_flag`, returns `sys_clk_en` to 1 on the next cycle, keeps `pd_flag` at 1 and does not assert `rst_req`.
- R8: An overflow while running sets `to_flag` and pulses `rst_req` for exactly one cycle, visible in the cycle after the overflowing tick.
- R9: A `wake_req` while halted returns `sys_clk_en` to 1 on the next cycle, with `to_flag` left at 0 and `pd_flag` at 1.
- R10: A `wdt_clr` pulse while running restarts the watchdog and clears `pd_flag` and `to_flag`. While halted, `wdt_clr` is ignored.
- R11: `sync_out` is the clock-enabled cycle count divided by four: low for two enabled cycles, then high for two, starting low. It holds still during halt.
- R12: `halt_req` while halted is ignored. A clear that arrives in the same cycle as a tick wins, so the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | One-cycle halt strobe from the decoder |
| wdt_clr | input | 1 | One-cycle watchdog clear strobe |
| wake_req | input | 1 | External wake-up request |
| osc_tick | input | 1 | One-cycle tick from the free-running watchdog oscillator |
| cfg_wdt_src | input | 1 | Watchdog tick source: 0 oscillator, 1 core clock / 4 |
| cfg_osc_en | input | 1 | Watchdog oscillator enable |
| sys_clk_en | output | 1 | Core clock enable |
| sync_out | output | 1 | Core clock divided by four |
| rst_req | output | 1 | One-cycle reset request on run-time overflow |
| pd_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Time-out flag |

## Verification
The hardest case to reach is an overflow that ends a halt. It requires the count to be driven to exactly its last value while the core clock is stopped, and it must be shown that ticks from before the halt were discarded. The stimulus applies several ticks before entry. It then counts oscillator pulses one by one across the halt, checking the clock enable and the flags after every pulse. It also inserts a repeated halt strobe and an ignored clear mid-way, since either one would shift the overflow point. For the clock-derived source, the bench tracks the divider phase from the clock enable it observes. This lets it predict the cycle of each watchdog tick arithmetically.

// File: rtl/halt_wdt_pkg.sv
package halt_wdt_pkg;
    typedef enum logic [0:0] {
        PM_RUN  = 1'b0,
        PM_HALT = 1'b1
    } pm_state_t;
endpackage

// File: rtl/hw_div4.sv
module hw_div4 #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sync_out,
    output logic wrap_tick
);
    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (en)
            phase_q <= phase_q + 1'b1;
    end

    assign sync_out  = phase_q[DIV_LOG2-1];
    assign wrap_tick = en & (&phase_q);
endmodule

// File: rtl/hw_wdt_count.sv
module hw_wdt_count #(
    parameter int WDT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic overflow
);
    logic [WDT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (restart)
            count_q <= '0;
        else if (tick)
            count_q <= count_q + 1'b1;
    end

    assign overflow = tick & ~restart & (&count_q);
endmodule

// File: rtl/hw_mode_fsm.sv
module hw_mode_fsm
    import halt_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic wake_req,
    input  logic wdt_clr,
    input  logic overflow,
    output logic clk_en,
    output logic cnt_restart,
    output logic pd_flag,
    output logic to_flag,
    output logic rst_req
);
    pm_state_t state_q, state_d;
    logic      running;

    assign running     = (state_q == PM_RUN);
    assign clk_en      = running;
    assign cnt_restart = running & (halt_req | wdt_clr);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN:  if (halt_req)             state_d = PM_HALT;  // enter
            PM_HALT: if (overflow || wake_req) state_d = PM_RUN;   // expire / wake
            default:                           state_d = PM_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_flag <= 1'b0;
            to_flag <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            unique case (state_q)
                PM_RUN: begin
                    if (halt_req) begin
                        pd_flag <= 1'b1;
                        to_flag <= 1'b0;
                    end else if (wdt_clr) begin
                        pd_flag <= 1'b0;
                        to_flag <= 1'b0;
                    end else if (overflow) begin
                        to_flag <= 1'b1;
                        rst_req <= 1'b1;
                    end
                end
                PM_HALT: begin
                    if (overflow)
                        to_flag <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/halt_wdt_ctrl.sv
module halt_wdt_ctrl #(
    parameter int WDT_W    = 4,
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic wdt_clr,
    input  logic wake_req,
    input  logic osc_tick,
    input  logic cfg_wdt_src,
    input  logic cfg_osc_en,
    output logic sys_clk_en,
    output logic sync_out,
    output logic rst_req,
    output logic pd_flag,
    output logic to_flag
);
    logic clk_en_w;
    logic sys_tick;
    logic wdt_tick;
    logic restart;
    logic ovf;

    hw_div4 #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en_w),
        .sync_out  (sync_out),
        .wrap_tick (sys_tick)
    );

    assign wdt_tick = cfg_wdt_src ? sys_tick : (osc_tick & cfg_osc_en);

    hw_wdt_count #(.WDT_W(WDT_W)) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (wdt_tick),
        .overflow (ovf)
    );

    hw_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .wake_req    (wake_req),
        .wdt_clr     (wdt_clr),
        .overflow    (ovf),
        .clk_en      (clk_en_w),
        .cnt_restart (restart),
        .pd_flag     (pd_flag),
        .to_flag     (to_flag),
        .rst_req     (rst_req)
    );

    assign sys_clk_en = clk_en_w;
endmodule

// File: rtl/halt_wdt_ctrl_chk.sv
module halt_wdt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic wdt_clr,
    input logic wake_req,
    input logic sys_clk_en,
    input logic sync_out,
    input logic rst_req,
    input logic pd_flag,
    input logic to_flag
);
    a_r2_halt_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && halt_req) |=> !sys_clk_en);

    a_r3_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && halt_req) |=> (pd_flag && !to_flag));

    a_r7_no_reset_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en |=> !rst_req);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r8_reset_implies_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> to_flag);

    a_r9_wake_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && wake_req) |=> sys_clk_en);

    a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && wdt_clr && !halt_req) |=> (!pd_flag && !to_flag));

    a_r11_sync_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en |=> $stable(sync_out));
endmodule

bind halt_wdt_ctrl halt_wdt_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .wdt_clr    (wdt_clr),
    .wake_req   (wake_req),
    .sys_clk_en (sys_clk_en),
    .sync_out   (sync_out),
    .rst_req    (rst_req),
    .pd_flag    (pd_flag),
    .to_flag    (to_flag)
);

// File: tb/halt_wdt_ctrl_test.sv
module halt_wdt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDT_W      = 4;
    localparam int FULL       = 1 << WDT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, wdt_clr = 1'b0, wake_req = 1'b0, osc_tick = 1'b0;
    logic cfg_wdt_src = 1'b0, cfg_osc_en = 1'b0;
    logic sys_clk_en, sync_out, rst_req, pd_flag, to_flag;

    int checks = 0;
    int fails = 0;
    int phase = 0;
    int cycles = 0;
    logic systick_now;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_wdt_ctrl #(.WDT_W(WDT_W), .DIV_LOG2(2)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_clr(wdt_clr),
        .wake_req(wake_req), .osc_tick(osc_tick), .cfg_wdt_src(cfg_wdt_src),
        .cfg_osc_en(cfg_osc_en), .sys_clk_en(sys_clk_en), .sync_out(sync_out),
        .rst_req(rst_req), .pd_flag(pd_flag), .to_flag(to_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic cyc(input logic h, input logic c, input logic w, input logic t);
        halt_req = h; wdt_clr = c; wake_req = w; osc_tick = t;
        if (sys_clk_en) begin
            systick_now = ((phase % 4) == 3);
            phase++;
        end else begin
            systick_now = 1'b0;
        end
        @(posedge clk);
        #1;
        halt_req = 0; wdt_clr = 0; wake_req = 0; osc_tick = 0;
        cycles++;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic sync_hold;
        int   n;
        #(CLK_PERIOD * 2 + 1);
        rst_n = 1'b1;
        #(CLK_PERIOD);

        // R1 reset state
        chk("R1 clk_en", sys_clk_en, 1'b1);
        chk("R1 pd", pd_flag, 1'b0);
        chk("R1 to", to_flag, 1'b0);
        chk("R1 rst_req", rst_req, 1'b0);
        chk("R1 sync", sync_out, 1'b0);
        phase = 0;

        // R11 divide by four while running; phase counted from reset
        // (one edge already passed since reset release)
        phase = 1;
        for (int i = 0; i < 12; i++) begin
            cyc(0, 0, 0, 0);
            chk("R11 sync", sync_out, ((phase % 4) >= 2));
        end

        // R4 / R8 overflow in run with oscillator source
        cfg_wdt_src = 0; cfg_osc_en = 1;
        cyc(0, 1, 0, 0);
        for (int i = 1; i <= FULL; i++) begin
            cyc(0, 0, 0, 1);
            chk("R4 to after tick", to_flag, (i == FULL));
            chk("R8 rst_req", rst_req, (i == FULL));
            if (i % 3 == 0) cyc(0, 0, 0, 0);
        end
        cyc(0, 0, 0, 0);
        chk("R8 rst_req single", rst_req, 1'b0);
        chk("R8 to held", to_flag, 1'b1);
        chk("R8 pd unchanged", pd_flag, 1'b0);

        // R10 clear in run
        cyc(0, 1, 0, 0);
        chk("R10 to cleared", to_flag, 1'b0);
        chk("R10 pd cleared", pd_flag, 1'b0);

        // R2 / R3 / R7 / R12 / R10: ticks before halt discarded
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
        cyc(1, 0, 0, 0);
        chk("R2 clk_en low", sys_clk_en, 1'b0);
        chk("R3 pd set", pd_flag, 1'b1);
        chk("R3 to clear", to_flag, 1'b0);
        sync_hold = sync_out;
        for (int i = 1; i <= FULL; i++) begin
            if (i == 8)  cyc(1, 0, 0, 0);   // R12 halt while halted ignored
            if (i == 10) cyc(0, 1, 0, 0);   // R10 clear while halted ignored
            cyc(0, 0, 0, 1);
            chk("R4 halt counting clk_en", sys_clk_en, (i == FULL));
            chk("R7 to on overflow", to_flag, (i == FULL));
            chk("R7 no rst_req", rst_req, 1'b0);
            chk("R7 pd held", pd_flag, 1'b1);
            if (i < FULL) chk("R11 sync frozen", sync_out, sync_hold);
            cyc(0, 0, 0, 0);
        end

        // R9 external wake
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0);
            chk("R2 stays halted", sys_clk_en, 1'b0);
        end
        cyc(0, 0, 1, 0);
        chk("R9 clk_en", sys_clk_en, 1'b1);
        chk("R9 to clear", to_flag, 1'b0);
        chk("R9 pd held", pd_flag, 1'b1);

        // R12 clear beats coinciding tick
        cyc(0, 1, 0, 1);
        for (int i = 1; i <= FULL; i++) begin
            cyc(0, 0, 0, 1);
            chk("R12 clear priority", to_flag, (i == FULL));
        end

        // R5 oscillator disabled
        cfg_osc_en = 0;
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 3 * FULL; i++) cyc(0, 0, 0, 1);
        chk("R5 no advance run", to_flag, 1'b0);
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 3 * FULL; i++) cyc(0, 0, 0, 1);
        chk("R5 no advance halt", to_flag, 1'b0);
        chk("R5 still halted", sys_clk_en, 1'b0);
        cyc(0, 0, 1, 0);

        // R6 clock-derived source
        cfg_wdt_src = 1; cfg_osc_en = 1;
        cyc(0, 1, 0, 0);
        n = 0;
        for (int i = 0; i < 8 * FULL && n < FULL; i++) begin
            cyc(0, 0, 0, 0);
            if (systick_now) n++;
            chk("R6 to at sixteenth sys tick", to_flag, (n == FULL));
            chk("R6 rst_req", rst_req, (n == FULL && systick_now));
        end
        chk("R6 reached overflow", to_flag, 1'b1);
        cyc(1, 0, 0, 0);
        sync_hold = sync_out;
        for (int i = 0; i < 8 * FULL; i++) cyc(0, 0, 0, 1);
        chk("R6 frozen in halt", to_flag, 1'b0);
        chk("R6 still halted", sys_clk_en, 1'b0);
        chk("R11 sync frozen long", sync_out, sync_hold);
        cyc(0, 0, 1, 0);
        chk("R9 wake again", sys_clk_en, 1'b1);

        finish_run();
    end
endmodule